// File: doc/BRIEF.md
# Video DRAM transfer cycle controller

This block watches the row, column, transfer, write-enable and serial-enable strobes of a dual-port video memory, all sampled on one system clock. When the transfer strobe is already low as the row strobe falls, the cycle becomes a transfer, and the write-enable and serial-enable levels at that edge pick one of three kinds. The kinds are a row-to-serial-buffer load, a serial-buffer-to-row store, and an input-mode switch that moves no data. The row address is captured at the row-strobe fall. The serial start column is captured at the column-strobe fall.

The transfer commits when the transfer strobe goes high while the row and column strobes are both still low. A load or a store then raises a move request toward the row array and the serial buffer. This request is a valid/ready stream: `mv_valid` stays high with a steady payload until the consumer raises `mv_ready`, and the consumer may stall it for any number of cycles. The block cannot be back-pressured anywhere else. An input-mode switch commits with no request. Every completed transfer produces a one-cycle done pulse, loads the serial start column for the external address counter, and updates the port direction flag. The only way into output direction is a load.

Top module: `vxfer_ctrl`

## Requirements
- R1: A row-strobe fall with `trg_n` high is not a transfer. No request, done pulse, start load or direction change follows, whatever the transfer strobe does later in that row cycle.
- R2: A transfer with `we_n` high at the row-strobe fall is a load. After commit, `mv_valid` rises with `mv_to_sam`=1 and `mv_row` equal to `addr` sampled at the row-strobe fall.
- R3: A transfer with `we_n` low and `se_n` low at the row-strobe fall is a store. After commit, `mv_valid` rises with `mv_to_sam`=0 and the latched row.
- R4: A transfer with `we_n` low and `se_n` high is an input-mode switch. It never raises `mv_valid`. On commit it pulses `xfer_done` and sets `ser_dir_out` to 0.
- R5: `addr` sampled at the column-strobe fall of a transfer appears on `ser_start` in the cycle when `xfer_done` pulses, and `ser_start_load` pulses in that same cycle.
- R6: A transfer commits only in a cycle where `trg_n` is sampled high while `ras_n` and `cas_n` are both low, after the column was latched. `mv_valid` rises one cycle after that sample.
- R7: If `ras_n` or `cas_n` goes high before the transfer strobe is released, the transfer is abandoned. There is no request, no done pulse and no direction change.
- R8: `ser_dir_out` (1 = output, 0 = input) resets to 1. It becomes 1 only when a load completes, and it becomes 0 when a store or an input-mode switch completes.
- R9: While `mv_valid` is high and `mv_ready` is low, `mv_valid`, `mv_row` and `mv_to_sam` hold. The handshake cycle ends the request.
- R10: `xfer_done` is a single-cycle pulse. For a load or store it comes one cycle after the handshake. For an input-mode switch it comes one cycle after the commit sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| trg_n | input | 1 | Transfer / output-enable strobe, active low |
| we_n | input | 1 | Write enable, picks transfer direction |
| se_n | input | 1 | Serial enable, separates store from input-mode switch |
| addr | input | ADDR_W | Multiplexed row/column address |
| mv_valid | output | 1 | Move request valid |
| mv_ready | input | 1 | Move request accepted |
| mv_to_sam | output | 1 | 1 = row to serial buffer, 0 = serial buffer to row |
| mv_row | output | ROW_W | Row to move |
| ser_dir_out | output | 1 | Serial port direction, 1 = output |
| ser_start | output | COL_W | Serial start column |
| ser_start_load | output | 1 | One-cycle pulse seeding the serial counter |
| xfer_done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
Every result is registered once behind the sampled strobes. `mv_valid` is due one clock after the cycle that samples the transfer strobe's release. For a load or store, `xfer_done`, `ser_start_load`, `ser_start` and the direction change are due one clock after the handshake; for an input-mode switch they are due one clock after the release. The bench drives inputs shortly before each rising edge and compares every output with a behavioural model at the falling edge, so each value is read a half period after it settles. The directed scenarios then count done pulses and request cycles over a whole row cycle, to confirm that abandoned and non-transfer cycles leave the port untouched.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
  typedef enum logic [1:0] {
    XK_LOAD   = 2'd0,
    XK_STORE  = 2'd1,
    XK_INMODE = 2'd2
  } xkind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COL  = 2'd1,
    ST_REL  = 2'd2,
    ST_MOVE = 2'd3
  } xstate_t;
endpackage

// File: rtl/vxfer_edge.sv
module vxfer_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fell
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl_n;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fell[i] = prev_q[i] & ~lvl_n[i];
  end
endmodule

// File: rtl/vxfer_decode.sv
module vxfer_decode
  import vxfer_pkg::*;
(
  input  logic   trg_n,
  input  logic   we_n,
  input  logic   se_n,
  output logic   is_xfer,
  output xkind_t kind
);
  always_comb begin
    is_xfer = ~trg_n;
    if (we_n)      kind = XK_LOAD;
    else if (se_n) kind = XK_INMODE;
    else           kind = XK_STORE;
  end
endmodule

// File: rtl/vxfer_seq.sv
module vxfer_seq
  import vxfer_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_fall,
  input  logic             cas_fall,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             trg_n,
  input  logic             is_xfer,
  input  xkind_t           kind_in,
  input  logic [ROW_W-1:0] row_in,
  input  logic [COL_W-1:0] col_in,
  input  logic             mv_ready,
  output logic             mv_valid,
  output logic             mv_to_sam,
  output logic [ROW_W-1:0] mv_row,
  output logic             fin,
  output xkind_t           fin_kind,
  output logic [COL_W-1:0] col_q
);
  xstate_t          st_q, st_d;
  xkind_t           kind_q;
  logic [ROW_W-1:0] row_q;
  logic             release_ok;

  assign release_ok = ~ras_n & ~cas_n & trg_n;

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (ras_fall && is_xfer) st_d = ST_COL;
      ST_COL: begin
        if (ras_n)         st_d = ST_IDLE;
        else if (cas_fall) st_d = ST_REL;
        else if (trg_n)    st_d = ST_IDLE;
      end
      ST_REL: begin
        if (ras_n || cas_n) st_d = ST_IDLE;
        else if (release_ok) begin
          if (kind_q == XK_INMODE) begin
            st_d = ST_IDLE;
            fin  = 1'b1;
          end else begin
            st_d = ST_MOVE;
          end
        end
      end
      ST_MOVE: if (mv_ready) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= XK_LOAD;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && ras_fall && is_xfer) begin
        kind_q <= kind_in;
        row_q  <= row_in;
      end
      if (st_q == ST_COL && !ras_n && cas_fall) col_q <= col_in;
    end
  end

  assign mv_valid  = (st_q == ST_MOVE);
  assign mv_to_sam = (kind_q == XK_LOAD);
  assign mv_row    = row_q;
  assign fin_kind  = kind_q;
endmodule

// File: rtl/vxfer_port_state.sv
module vxfer_port_state
  import vxfer_pkg::*;
#(
  parameter int   COL_W     = 8,
  parameter logic DIR_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fin,
  input  xkind_t           fin_kind,
  input  logic [COL_W-1:0] col_q,
  output logic             ser_dir_out,
  output logic [COL_W-1:0] ser_start,
  output logic             ser_start_load,
  output logic             xfer_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_dir_out    <= DIR_RESET;
      ser_start      <= '0;
      ser_start_load <= 1'b0;
      xfer_done      <= 1'b0;
    end else begin
      ser_start_load <= fin;
      xfer_done      <= fin;
      if (fin) begin
        ser_start   <= col_q;
        ser_dir_out <= (fin_kind == XK_LOAD);
      end
    end
  end
endmodule

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl
  import vxfer_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              trg_n,
  input  logic              we_n,
  input  logic              se_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic              mv_to_sam,
  output logic [ROW_W-1:0]  mv_row,
  output logic              ser_dir_out,
  output logic [COL_W-1:0]  ser_start,
  output logic              ser_start_load,
  output logic              xfer_done
);
  localparam int NSTB = 2;

  logic [NSTB-1:0]  stb_fell;
  logic             is_xfer;
  xkind_t           kind;
  logic             fin;
  xkind_t           fin_kind;
  logic [COL_W-1:0] col_q;

  vxfer_edge #(.N(NSTB)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_n ({cas_n, ras_n}),
    .fell  (stb_fell)
  );

  vxfer_decode u_dec (
    .trg_n   (trg_n),
    .we_n    (we_n),
    .se_n    (se_n),
    .is_xfer (is_xfer),
    .kind    (kind)
  );

  vxfer_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_fall  (stb_fell[0]),
    .cas_fall  (stb_fell[1]),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .trg_n     (trg_n),
    .is_xfer   (is_xfer),
    .kind_in   (kind),
    .row_in    (addr[ROW_W-1:0]),
    .col_in    (addr[COL_W-1:0]),
    .mv_ready  (mv_ready),
    .mv_valid  (mv_valid),
    .mv_to_sam (mv_to_sam),
    .mv_row    (mv_row),
    .fin       (fin),
    .fin_kind  (fin_kind),
    .col_q     (col_q)
  );

  vxfer_port_state #(.COL_W(COL_W), .DIR_RESET(1'b1)) u_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .fin            (fin),
    .fin_kind       (fin_kind),
    .col_q          (col_q),
    .ser_dir_out    (ser_dir_out),
    .ser_start      (ser_start),
    .ser_start_load (ser_start_load),
    .xfer_done      (xfer_done)
  );
endmodule

// File: rtl/vxfer_ctrl_chk.sv
module vxfer_ctrl_chk #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              trg_n,
  input logic              we_n,
  input logic              se_n,
  input logic [ADDR_W-1:0] addr,
  input logic              mv_valid,
  input logic              mv_ready,
  input logic              mv_to_sam,
  input logic [ROW_W-1:0]  mv_row,
  input logic              ser_dir_out,
  input logic [COL_W-1:0]  ser_start,
  input logic              ser_start_load,
  input logic              xfer_done
);
  // R9
  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_row) && $stable(mv_to_sam)));

  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R5
  a_r5_load_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start_load == xfer_done);

  // R6
  a_r6_commit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mv_valid) |-> $past(trg_n && !ras_n && !cas_n));

  // R8
  a_r8_dir_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_dir_out != $past(ser_dir_out)) |-> xfer_done);

  // R8
  a_r8_output_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_dir_out) |-> $past(mv_valid && mv_ready && mv_to_sam));

  // R4
  a_r4_inmode_sets_input: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !$past(mv_valid)) |-> !ser_dir_out);
endmodule

bind vxfer_ctrl vxfer_ctrl_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_vxfer_ctrl.sv
module sim_vxfer_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1, we_n = 1'b1, se_n = 1'b1;
  logic [7:0] addr = '0;
  logic       mv_ready = 1'b1;
  logic       mv_valid, mv_to_sam, ser_dir_out, ser_start_load, xfer_done;
  logic [7:0] mv_row, ser_start;

  int checks = 0, failures = 0;
  int n_done = 0, n_valid = 0, stall = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vxfer_ctrl u0 (.*);

  // behavioural reference model
  int m_ph, m_kind, m_row, m_col, m_dir, m_start, m_done;
  logic p_ras, p_cas;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_kind <= 0; m_row <= 0; m_col <= 0;
      m_dir <= 1; m_start <= 0; m_done <= 0; p_ras <= 1; p_cas <= 1;
    end else begin
      m_done <= 0;
      p_ras  <= ras_n;
      p_cas  <= cas_n;
      case (m_ph)
        0: if (p_ras && !ras_n && !trg_n) begin
             m_kind <= we_n ? 0 : (se_n ? 2 : 1);
             m_row  <= addr; m_ph <= 1;
           end
        1: if (ras_n) m_ph <= 0;
           else if (p_cas && !cas_n) begin m_col <= addr; m_ph <= 2; end
           else if (trg_n) m_ph <= 0;
        2: if (ras_n || cas_n) m_ph <= 0;
           else if (trg_n) begin
             if (m_kind == 2) begin
               m_done <= 1; m_start <= m_col; m_dir <= 0; m_ph <= 0;
             end else m_ph <= 3;
           end
        default: if (mv_ready) begin
             m_done <= 1; m_start <= m_col; m_dir <= (m_kind == 0); m_ph <= 0;
           end
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R6 mv_valid", mv_valid, m_ph == 3);
    if (mv_valid && m_ph == 3) begin
      chk(m_kind == 0 ? "R2 mv_to_sam" : "R3 mv_to_sam", mv_to_sam, m_kind == 0);
      chk("R2 mv_row", mv_row, m_row);
    end
    chk("R8 ser_dir_out", ser_dir_out, m_dir);
    chk("R10 xfer_done", xfer_done, m_done);
    chk("R5 ser_start_load", ser_start_load, m_done);
    chk("R5 ser_start", ser_start, m_start);
    if (xfer_done) n_done++;
    if (mv_valid) n_valid++;
  end

  task automatic tick();
    @(negedge clk);
    #1;
    mv_ready = (stall == 0);
    if (stall > 0) stall--;
  endtask

  task automatic idle(input int n);
    ras_n = 1; cas_n = 1; trg_n = 1; we_n = 1; se_n = 1;
    for (int i = 0; i < n; i++) tick();
  endtask

  // mode 0: normal, 1: row strobe rises early, 2: column strobe rises early
  task automatic xfer(input logic t, input logic w, input logic s,
                      input logic [7:0] row, input logic [7:0] col, input int mode);
    trg_n = t; we_n = w; se_n = s; addr = row; tick();
    ras_n = 0; tick();
    we_n = 1; se_n = 1; addr = col; cas_n = 0; tick();
    if (t) begin trg_n = 0; tick(); end
    tick();
    if (mode == 1) begin ras_n = 1; tick(); end
    if (mode == 2) begin cas_n = 1; tick(); end
    trg_n = 1; tick();
    for (int i = 0; i < 12; i++) tick();
    idle(2);
  endtask

  int d0, v0, dir0;

  initial begin
    idle(3);
    rst_n = 1;
    tick();
    chk("R8 reset dir", ser_dir_out, 1);
    chk("R9 reset valid", mv_valid, 0);
    chk("R10 reset done", xfer_done, 0);

    // R3 store
    d0 = n_done; v0 = n_valid;
    xfer(0, 0, 0, 8'h3C, 8'h11, 0);
    chk("R3 done count", n_done - d0, 1);
    chk("R3 valid cycles", n_valid - v0, 1);
    chk("R8 dir after store", ser_dir_out, 0);
    chk("R5 start after store", ser_start, 8'h11);

    // R2 load with back-pressure (R9)
    d0 = n_done; v0 = n_valid; stall = 9;
    xfer(0, 1, 0, 8'hA5, 8'hF0, 0);
    chk("R2 done count", n_done - d0, 1);
    chk("R9 stalled valid cycles", n_valid - v0 > 1, 1);
    chk("R8 dir after load", ser_dir_out, 1);
    chk("R5 start after load", ser_start, 8'hF0);

    // R4 input-mode switch
    d0 = n_done; v0 = n_valid;
    xfer(0, 0, 1, 8'h07, 8'hFF, 0);
    chk("R4 done count", n_done - d0, 1);
    chk("R4 no request", n_valid - v0, 0);
    chk("R4 dir input", ser_dir_out, 0);
    chk("R5 start after inmode", ser_start, 8'hFF);

    // R1 non-transfer while in input mode
    d0 = n_done; v0 = n_valid;
    xfer(1, 1, 0, 8'h55, 8'h22, 0);
    chk("R1 no done", n_done - d0, 0);
    chk("R1 no request", n_valid - v0, 0);
    chk("R1 dir kept", ser_dir_out, 0);
    chk("R1 start kept", ser_start, 8'hFF);

    // R7 aborts of a load
    d0 = n_done; v0 = n_valid;
    xfer(0, 1, 0, 8'h99, 8'h33, 1);
    xfer(0, 1, 0, 8'h98, 8'h34, 2);
    chk("R7 no done", n_done - d0, 0);
    chk("R7 no request", n_valid - v0, 0);
    chk("R7 dir kept", ser_dir_out, 0);

    // R6 back-to-back load then store, row 0 and 255 boundaries
    d0 = n_done;
    xfer(0, 1, 1, 8'h00, 8'h00, 0);
    chk("R8 load again", ser_dir_out, 1);
    stall = 3;
    xfer(0, 0, 0, 8'hFF, 8'h80, 0);
    chk("R6 two commits", n_done - d0, 2);
    chk("R8 store again", ser_dir_out, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule